// File: doc/BRIEF.md
# Compare-to-Predicate Unit

This unit is one execution stage for integer compare operations that write a single predicate bit instead of a register value. Each cycle it may accept one operation: two 64-bit operands, a 7-bit opcode, an 8-bit destination field and the number of the channel that issued it. The destination field packs a 3-bit condition code above a 5-bit predicate index. One cycle later the unit reports exactly one outcome. It can be a predicate write with its index and value, an illegal-opcode flag, an unimplemented-operation flag, or nothing.

Two families of compare are handled, each in 32-bit and 64-bit form. Relational compares test the operands against each other with signed or unsigned ordering. Mask tests first AND the operands together and then test that product for zero, for a negative value, or for signed less-or-equal to zero. The third channel of each three-channel cluster has no compare hardware. An operation steered there is refused. Operand fetch and the predicate register file lie outside this unit.

The result is held in a four-state outcome register. The states are `ST_QUIET` (no result), `ST_WRITE` (predicate write), `ST_ILLEGAL` (illegal-opcode flag) and `ST_UNIMPL` (unimplemented-operation flag). On every clock the next state is chosen again from the current input, so any state can move to any other:
- A cycle without a valid compare goes to `ST_QUIET`.
- A compare on a refused channel goes to `ST_UNIMPL`.
- A relational compare with a supported code goes to `ST_WRITE`, and one with an unsupported code goes to `ST_UNIMPL`.
- A mask test with a supported code goes to `ST_WRITE`, and one with an unsupported code goes to `ST_ILLEGAL`.

Reset enters `ST_QUIET`.

Top module: `pred_cmp_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pred_we, pred_idx, pred_val, illegal_op and unimpl_op are all zero.
- R2: An outcome appears on the outputs exactly one clock after the cycle in which in_valid was high. A cycle with in_valid low gives all outputs zero in the next cycle, whatever the other inputs are.
- R3: Opcode 0x21 is a 64-bit relational compare of src_a against src_b. Condition code 1 is unsigned less-than, 2 is equal, 3 is unsigned less-or-equal, 6 is signed less-than and 7 is signed less-or-equal. pred_val is 1 when the relation holds and 0 when it does not.
- R4: Opcode 0x20 is the same relational compare applied to bits [31:0] of each operand only. Bits [63:32] have no effect, and the signed codes treat bit 31 as the sign.
- R5: A relational compare with condition code 0, 4 or 5 raises unimpl_op and produces no predicate write.
- R6: Opcode 0x23 ANDs the full 64-bit operands. Code 2 yields 1 when the product is zero, code 4 yields 1 when bit 63 of the product is set, and code 7 yields 1 when the product is zero or negative as a signed value.
- R7: Opcode 0x22 sign-extends bits [31:0] of each operand from bit 31 before the AND and then applies the R6 tests. Bits [63:32] have no effect.
- R8: A mask test with condition code 0, 1, 3, 5 or 6 raises illegal_op and produces no predicate write.
- R9: Any of the opcodes 0x20 to 0x23 issued on channel 2 or channel 5 raises unimpl_op and produces no predicate write, whatever the condition code. This refusal takes precedence over R5 and R8.
- R10: The condition code is bits [7:5] of dst_field. On a predicate write, pred_idx equals bits [4:0] of dst_field.
- R11: Any opcode outside 0x20 to 0x23 produces no write and no flag.
- R12: In any cycle at most one of pred_we, illegal_op and unimpl_op is high. pred_idx and pred_val are zero whenever pred_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 7 | Operation code |
| dst_field | input | 8 | Condition code [7:5] and predicate index [4:0] |
| channel | input | 3 | Number of the issuing channel (0 to 5) |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| pred_we | output | 1 | Predicate write strobe |
| pred_idx | output | 5 | Index of the predicate being written |
| pred_val | output | 1 | Value of the predicate being written |
| illegal_op | output | 1 | Mask test with an unsupported condition code |
| unimpl_op | output | 1 | Unsupported relational code, or compare on a refused channel |

## Verification
The checker watches the following on every cycle:
- The three outcomes exclude each other.
- Index and value are zero when no write occurs.
- Any outcome follows a valid input.
- The written index tracks the destination field.
- A refused channel always leads to the unimplemented flag.
- A 64-bit equality of identical operands always writes a one.

The truth of each relation for particular operand values can only be shown by the bench's scenarios. These cover the sign boundary at bit 31 and bit 63, upper-half garbage on the narrow forms, every condition code in each family, and the precedence of channel refusal over a bad code.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int unsigned DATA_W            = 64;
    localparam int unsigned HALF_W            = 32;
    localparam int unsigned IDX_W             = 5;
    localparam int unsigned COND_W            = 3;
    localparam int unsigned OPC_W             = 7;
    localparam int unsigned CH_W              = 3;
    localparam int unsigned LANES_PER_CLUSTER = 3;

    localparam logic [OPC_W-1:0] OPC_REL_NARROW  = 7'h20;
    localparam logic [OPC_W-1:0] OPC_REL_WIDE    = 7'h21;
    localparam logic [OPC_W-1:0] OPC_MASK_NARROW = 7'h22;
    localparam logic [OPC_W-1:0] OPC_MASK_WIDE   = 7'h23;

    localparam logic [COND_W-1:0] CC_ULT  = 3'd1;
    localparam logic [COND_W-1:0] CC_EQ   = 3'd2;
    localparam logic [COND_W-1:0] CC_ULE  = 3'd3;
    localparam logic [COND_W-1:0] CC_NEG  = 3'd4;
    localparam logic [COND_W-1:0] CC_SLT  = 3'd6;
    localparam logic [COND_W-1:0] CC_SLE  = 3'd7;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_WRITE   = 2'd1,
        ST_ILLEGAL = 2'd2,
        ST_UNIMPL  = 2'd3
    } pcu_state_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_REL  = 2'd1,
        K_MASK = 2'd2
    } cmp_kind_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
#(
    parameter int unsigned OW     = OPC_W,
    parameter int unsigned CW     = CH_W,
    parameter int unsigned LANES  = LANES_PER_CLUSTER
) (
    input  logic [OW-1:0] opcode,
    input  logic [CW-1:0] channel,
    output cmp_kind_e     kind,
    output logic          narrow,
    output logic          lane_ok
);
    logic [31:0] lane_pos;

    always_comb begin
        lane_pos = 32'(channel) % LANES;
        lane_ok  = (lane_pos != LANES - 1);
        kind     = K_NONE;
        narrow   = 1'b0;
        unique case (opcode)
            OPC_REL_NARROW:  begin kind = K_REL;  narrow = 1'b1; end
            OPC_REL_WIDE:    begin kind = K_REL;  narrow = 1'b0; end
            OPC_MASK_NARROW: begin kind = K_MASK; narrow = 1'b1; end
            OPC_MASK_WIDE:   begin kind = K_MASK; narrow = 1'b0; end
            default:         begin kind = K_NONE; narrow = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pcu_widen.sv
module pcu_widen
    import pcu_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned HW = HALF_W
) (
    input  logic          narrow,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] wide
);
    localparam int unsigned PAD_W = DW - HW;

    always_comb begin
        if (narrow) wide = {{PAD_W{raw[HW-1]}}, raw[HW-1:0]};
        else        wide = raw;
    end
endmodule

// File: rtl/pcu_relcmp.sv
module pcu_relcmp
    import pcu_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CCW = COND_W
) (
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [CCW-1:0] cond,
    output logic           hit,
    output logic           code_ok
);
    logic eq, lt_u, lt_s;

    always_comb begin
        eq   = (a == b);
        lt_u = (a < b);
        lt_s = ($signed(a) < $signed(b));
        hit     = 1'b0;
        code_ok = 1'b1;
        unique case (cond)
            CC_ULT:  hit = lt_u;
            CC_EQ:   hit = eq;
            CC_ULE:  hit = lt_u | eq;
            CC_SLT:  hit = lt_s;
            CC_SLE:  hit = lt_s | eq;
            default: code_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcu_masktest.sv
module pcu_masktest
    import pcu_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CCW = COND_W
) (
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [CCW-1:0] cond,
    output logic           hit,
    output logic           code_ok
);
    logic [DW-1:0] prod;
    logic          is_zero, is_neg;

    always_comb begin
        prod    = a & b;
        is_zero = (prod == '0);
        is_neg  = prod[DW-1];
        hit     = 1'b0;
        code_ok = 1'b1;
        unique case (cond)
            CC_EQ:   hit = is_zero;
            CC_NEG:  hit = is_neg;
            CC_SLE:  hit = is_zero | is_neg;
            default: code_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
    import pcu_pkg::*;
#(
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned HW  = HALF_W,
    parameter int unsigned IW  = IDX_W,
    parameter int unsigned OW  = OPC_W,
    parameter int unsigned CW  = CH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [OW-1:0] opcode,
    input  logic [IW+COND_W-1:0] dst_field,
    input  logic [CW-1:0] channel,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic          pred_we,
    output logic [IW-1:0] pred_idx,
    output logic          pred_val,
    output logic          illegal_op,
    output logic          unimpl_op
);
    localparam int unsigned FW = IW + COND_W;

    cmp_kind_e         kind;
    logic              narrow, lane_ok;
    logic [DW-1:0]     wa, wb;
    logic [COND_W-1:0] cond;
    logic              rel_hit, rel_ok, msk_hit, msk_ok;

    pcu_state_e        state_q, state_d;
    logic [IW-1:0]     idx_q, idx_d;
    logic              val_q, val_d;

    assign cond = dst_field[FW-1:IW];

    pcu_decode #(.OW(OW), .CW(CW), .LANES(LANES_PER_CLUSTER)) u_dec (
        .opcode (opcode),
        .channel(channel),
        .kind   (kind),
        .narrow (narrow),
        .lane_ok(lane_ok)
    );

    pcu_widen #(.DW(DW), .HW(HW)) u_wa (.narrow(narrow), .raw(src_a), .wide(wa));
    pcu_widen #(.DW(DW), .HW(HW)) u_wb (.narrow(narrow), .raw(src_b), .wide(wb));

    pcu_relcmp #(.DW(DW), .CCW(COND_W)) u_rel (
        .a(wa), .b(wb), .cond(cond), .hit(rel_hit), .code_ok(rel_ok)
    );

    pcu_masktest #(.DW(DW), .CCW(COND_W)) u_msk (
        .a(wa), .b(wb), .cond(cond), .hit(msk_hit), .code_ok(msk_ok)
    );

    // next-state selection
    always_comb begin
        state_d = ST_QUIET;
        idx_d   = '0;
        val_d   = 1'b0;
        if (in_valid && kind != K_NONE) begin
            if (!lane_ok) begin
                state_d = ST_UNIMPL;
            end else begin
                unique case (kind)
                    K_REL: begin
                        if (rel_ok) begin
                            state_d = ST_WRITE;
                            idx_d   = dst_field[IW-1:0];
                            val_d   = rel_hit;
                        end else begin
                            state_d = ST_UNIMPL;
                        end
                    end
                    K_MASK: begin
                        if (msk_ok) begin
                            state_d = ST_WRITE;
                            idx_d   = dst_field[IW-1:0];
                            val_d   = msk_hit;
                        end else begin
                            state_d = ST_ILLEGAL;
                        end
                    end
                    default: state_d = ST_QUIET;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            idx_q   <= '0;
            val_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            val_q   <= val_d;
        end
    end

    // outputs from state
    always_comb begin
        pred_we    = 1'b0;
        pred_idx   = '0;
        pred_val   = 1'b0;
        illegal_op = 1'b0;
        unimpl_op  = 1'b0;
        unique case (state_q)
            ST_QUIET:   ;
            ST_WRITE:   begin pred_we = 1'b1; pred_idx = idx_q; pred_val = val_q; end
            ST_ILLEGAL: illegal_op = 1'b1;
            ST_UNIMPL:  unimpl_op  = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [6:0]  opcode,
    input logic [7:0]  dst_field,
    input logic [2:0]  channel,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic        pred_we,
    input logic [4:0]  pred_idx,
    input logic        pred_val,
    input logic        illegal_op,
    input logic        unimpl_op
);
    logic is_cmp;
    assign is_cmp = (opcode >= 7'h20) && (opcode <= 7'h23);

    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pred_we, illegal_op, unimpl_op}));

    assert_quiet_fields_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_we |-> (pred_idx == 5'd0 && !pred_val));

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!pred_we && !illegal_op && !unimpl_op));

    assert_index_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!pred_we || pred_idx == $past(dst_field[4:0])));

    assert_lane_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp && (channel == 3'd2 || channel == 3'd5)) |=> unimpl_op);

    assert_self_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 7'h21 && dst_field[7:5] == 3'd2 && src_a == src_b
         && channel != 3'd2 && channel != 3'd5) |=> (pred_we && pred_val));
endmodule

bind pred_cmp_unit pcu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .dst_field (dst_field),
    .channel   (channel),
    .src_a     (src_a),
    .src_b     (src_b),
    .pred_we   (pred_we),
    .pred_idx  (pred_idx),
    .pred_val  (pred_val),
    .illegal_op(illegal_op),
    .unimpl_op (unimpl_op)
);

// File: tb/pred_cmp_unit_tb.sv
module pred_cmp_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  opcode = '0;
    logic [7:0]  dst_field = '0;
    logic [2:0]  channel = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        pred_we, pred_val, illegal_op, unimpl_op;
    logic [4:0]  pred_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_cmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_field(dst_field), .channel(channel), .src_a(src_a), .src_b(src_b),
        .pred_we(pred_we), .pred_idx(pred_idx), .pred_val(pred_val),
        .illegal_op(illegal_op), .unimpl_op(unimpl_op)
    );

    // expected {we, idx, val, ill, un}
    function automatic logic [8:0] model(input logic v, input logic [6:0] op,
                                         input logic [7:0] df, input logic [2:0] ch,
                                         input logic [63:0] a, input logic [63:0] b);
        int cc;
        longint sa, sb, m;
        logic [63:0] ua, ub;
        bit res;
        cc = int'(df[7:5]);
        if (!v || op < 7'h20 || op > 7'h23) return 9'b0;
        if (ch == 3'd2 || ch == 3'd5) return 9'b0_00000_0_0_1;
        if (op == 7'h20 || op == 7'h22) begin
            sa = longint'(int'(a[31:0]));
            sb = longint'(int'(b[31:0]));
            ua = {32'b0, a[31:0]};
            ub = {32'b0, b[31:0]};
        end else begin
            sa = longint'(a);
            sb = longint'(b);
            ua = a;
            ub = b;
        end
        if (op == 7'h20 || op == 7'h21) begin
            case (cc)
                1: res = ua < ub;
                2: res = ua == ub;
                3: res = ua <= ub;
                6: res = sa < sb;
                7: res = sa <= sb;
                default: return 9'b0_00000_0_0_1;
            endcase
        end else begin
            m = sa & sb;
            case (cc)
                2: res = (m == 0);
                4: res = (m < 0);
                7: res = (m <= 0);
                default: return 9'b0_00000_0_1_0;
            endcase
        end
        return {1'b1, df[4:0], res, 2'b00};
    endfunction

    task automatic compare(input logic [8:0] exp, input string tag);
        logic [8:0] got;
        got = {pred_we, pred_idx, pred_val, illegal_op, unimpl_op};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got we=%0b idx=%0d val=%0b ill=%0b un=%0b, expected we=%0b idx=%0d val=%0b ill=%0b un=%0b",
                     tag, got[8], got[7:3], got[2], got[1], got[0],
                     exp[8], exp[7:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // drive at negedge, compare at next negedge (one register stage)
    task automatic step(input logic v, input logic [6:0] op, input logic [7:0] df,
                        input logic [2:0] ch, input logic [63:0] a, input logic [63:0] b,
                        input string tag);
        logic [8:0] exp;
        in_valid = v; opcode = op; dst_field = df; channel = ch; src_a = a; src_b = b;
        exp = model(v, op, df, ch, a, b);
        @(negedge clk);
        compare(exp, tag);
    endtask

    function automatic logic [7:0] fld(input int cc, input int idx);
        return {3'(cc), 5'(idx)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset
        in_valid = 1'b1; opcode = 7'h21; dst_field = fld(2, 3); src_a = 5; src_b = 5;
        repeat (3) @(negedge clk);
        compare(9'b0, "R1 during reset");
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare(9'b0, "R1 after reset");

        // R3 wide relational, every code, less/equal/greater
        for (int cc = 0; cc < 8; cc++) begin
            step(1, 7'h21, fld(cc, cc + 1), 3'd0, 64'd3, 64'd9, "R3 wide lt");
            step(1, 7'h21, fld(cc, cc + 9), 3'd1, 64'd9, 64'd9, "R3 wide eq");
            step(1, 7'h21, fld(cc, 31), 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R3 wide sign R5");
        end
        step(1, 7'h21, fld(6, 4), 3'd4, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R3 min vs max");
        // R4 narrow relational: upper halves ignored, bit 31 sign
        for (int cc = 0; cc < 8; cc++) begin
            step(1, 7'h20, fld(cc, 7), 3'd0, 64'hDEAD_0000_0000_0005, 64'h0000_BEEF_0000_0005, "R4 narrow eq garbage");
            step(1, 7'h20, fld(cc, 8), 3'd1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, "R4 narrow sign");
        end
        // R5 unsupported relational codes
        step(1, 7'h20, fld(0, 2), 3'd0, 1, 2, "R5 code0");
        step(1, 7'h21, fld(4, 2), 3'd3, 1, 2, "R5 code4");
        step(1, 7'h21, fld(5, 2), 3'd4, 1, 2, "R5 code5");
        // R6 / R8 wide mask tests
        for (int cc = 0; cc < 8; cc++) begin
            step(1, 7'h23, fld(cc, 12), 3'd0, 64'hF0F0, 64'h0F0F, "R6 mask zero R8");
            step(1, 7'h23, fld(cc, 13), 3'd1, 64'h8000_0000_0000_00FF, 64'hC000_0000_0000_0001, "R6 mask neg R8");
            step(1, 7'h23, fld(cc, 14), 3'd3, 64'h0000_0000_0000_00FF, 64'h10, "R6 mask pos R8");
        end
        // R7 narrow mask: sign-extend from bit 31, upper ignored
        for (int cc = 0; cc < 8; cc++) begin
            step(1, 7'h22, fld(cc, 20), 3'd0, 64'h0000_0000_8000_0001, 64'h0000_0000_8000_0000, "R7 narrow neg");
            step(1, 7'h22, fld(cc, 21), 3'd4, 64'hFFFF_FFFF_0000_0F00, 64'hFFFF_FFFF_0000_00F0, "R7 narrow zero garbage");
        end
        // R9 refused channels, precedence over bad codes
        for (int op = 32; op < 36; op++) begin
            step(1, 7'(op), fld(2, 1), 3'd2, 4, 4, "R9 ch2");
            step(1, 7'(op), fld(5, 1), 3'd5, 4, 4, "R9 ch5 bad code");
        end
        // R11 other opcodes, R2 invalid cycles
        step(1, 7'h24, fld(2, 6), 3'd0, 0, 0, "R11 opcode 0x24");
        step(1, 7'h1F, fld(2, 6), 3'd0, 0, 0, "R11 opcode 0x1f");
        step(0, 7'h21, fld(2, 6), 3'd0, 7, 7, "R2 invalid ignored");
        step(1, 7'h21, fld(2, 6), 3'd0, 7, 7, "R2 back to back R10");
        step(1, 7'h21, fld(1, 30), 3'd1, 7, 7, "R2 back to back R10");
        // random sweep R12
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 4 == 0) rb = ra;
            step(1'($urandom % 5 != 0), 7'(32 + $urandom % 5), 8'($urandom),
                 3'($urandom % 6), ra, rb, "R12 random");
        end
        step(0, 0, 0, 0, 0, 0, "R2 drain");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule